// File: doc/BRIEF.md
# Output Impedance Code Sequencer

This controller owns the impedance codes applied to a set of output drivers, one code for the pull-up side and one for the pull-down side. A calibration circuit outside the block measures an external resistor and supplies digital target codes. The sought driver impedance is one fifth of that resistor. The sequencer walks each applied code toward its target, one step at a time. It moves only while the data outputs sit in high impedance, so no driven transfer ever sees the driver strength change mid-bit.

The output-tristated flag is asserted by the surrounding logic during write and deselect cycles. It is also asserted when the asynchronous output enable is held off. A window opens only when the flag is high at two consecutive rising edges. A disable that is stable around an edge therefore counts, and a glitchy one does not. A shared prescaler counts window cycles, so that a sweep across the whole code range finishes within a fixed budget of update cycles. When the calibration input is sensed as open, both targets become the maximum-impedance code.

Top module: `zq_code_seq`

## Requirements
- R1: During and right after reset, both applied codes are 0 (code 0 is minimum impedance; the all-ones code is maximum impedance), and the prescaler count restarts from zero.
- R2: An applied code changes only at a rising edge where `out_hiz` is high and was also high at the previous rising edge (an update window). A code holds through any edge without such a window.
- R3: An applied code changes by exactly one step in any single cycle, or not at all.
- R4: A code that moves goes toward its effective target. It increments when below the target and decrements when above it.
- R5: When `open_sense` is 1, the effective target of both codes is the all-ones (maximum-impedance) code, whatever `tgt_pu` and `tgt_pd` hold.
- R6: A step is taken on every DIV-th update window, where DIV = SWEEP_CYC / (2^CODE_W − 1), which is 66 by default. Window cycles are counted across gaps: cycles without a window neither advance nor clear the count.
- R7: From reset with a steady window, a code goes from 0 to the all-ones code within SWEEP_CYC cycles. By default it reaches 30 after edge 2046 and 31 after edge 2047, counted from the first edge after reset.
- R8: The pull-up and pull-down codes follow their own targets independently and share only the window and prescaler timing.
- R9: A code equal to its effective target stays there on a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| open_sense | input | 1 | Calibration pin sensed as open; forces the maximum-impedance target |
| out_hiz | input | 1 | Data outputs currently in high impedance |
| tgt_pu | input | CODE_W | Pull-up target code from calibration |
| tgt_pd | input | CODE_W | Pull-down target code from calibration |
| app_pu | output | CODE_W | Applied pull-up impedance code |
| app_pd | output | CODE_W | Applied pull-down impedance code |

## Verification
The bench targets the single-edge high-impedance pulse. A design that treats it as a window changes the code while the outputs are driven. It also splits windows across gaps. A prescaler that clears in the gap never steps under intermittent traffic, and one that keeps counting steps while the outputs drive. The exact edge of the last step in a full sweep exposes an off-by-one divider or a missing window qualifier, which shows as a late or early code. Open sense with a low pin target catches a design that ignores the override. A pull-down code that tracks the pull-up target shows crossed legs.

// File: rtl/zq_code_seq.sv
module zq_code_seq #(
  parameter int CODE_W    = 5,
  parameter int SWEEP_CYC = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_sense,
  input  logic              out_hiz,
  input  logic [CODE_W-1:0] tgt_pu,
  input  logic [CODE_W-1:0] tgt_pd,
  output logic [CODE_W-1:0] app_pu,
  output logic [CODE_W-1:0] app_pd
);
  localparam int STEPS = (1 << CODE_W) - 1;
  localparam int DIV   = (SWEEP_CYC / STEPS) < 1 ? 1 : SWEEP_CYC / STEPS;
  localparam int CNT_W = DIV > 1 ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(DIV - 1);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] ONE      = CODE_W'(1);

  logic             hiz_q;
  logic [CNT_W-1:0] cnt;
  logic             win, tick;
  logic [CODE_W-1:0] eff_pu, eff_pd;

  assign win    = out_hiz & hiz_q;
  assign tick   = win && (cnt == CNT_LAST);
  assign eff_pu = open_sense ? CODE_MAX : tgt_pu;
  assign eff_pd = open_sense ? CODE_MAX : tgt_pd;

  function automatic logic [CODE_W-1:0] toward(input logic [CODE_W-1:0] cur,
                                               input logic [CODE_W-1:0] tgt);
    if (cur < tgt)      return cur + ONE;
    else if (cur > tgt) return cur - ONE;
    else                return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hiz_q  <= 1'b0;
      cnt    <= '0;
      app_pu <= '0;
      app_pd <= '0;
    end else begin
      hiz_q <= out_hiz;
      if (win) cnt <= tick ? '0 : cnt + CNT_W'(1);
      if (tick) begin
        app_pu <= toward(app_pu, eff_pu);
        app_pd <= toward(app_pd, eff_pd);
      end
    end
  end

  AST_PU_ONLY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (app_pu != $past(app_pu)) |-> ($past(out_hiz, 1) && $past(out_hiz, 2))); // R2
  AST_PD_ONLY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (app_pd != $past(app_pd)) |-> ($past(out_hiz, 1) && $past(out_hiz, 2))); // R2
  AST_PU_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (app_pu != $past(app_pu)) |-> ((app_pu == $past(app_pu) + ONE) || ($past(app_pu) == app_pu + ONE))); // R3
  AST_PD_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (app_pd != $past(app_pd)) |-> ((app_pd == $past(app_pd) + ONE) || ($past(app_pd) == app_pd + ONE))); // R3
  AST_PU_TOWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (app_pu > $past(app_pu)) |-> ($past(open_sense) || ($past(tgt_pu) > $past(app_pu)))); // R4
  AST_PD_OPEN_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(open_sense) && app_pd != $past(app_pd)) |-> (app_pd > $past(app_pd))); // R5
endmodule

// File: tb/zq_code_seq_tb.sv
`timescale 1ns/1ps
module zq_code_seq_tb;
  localparam int W   = 5;
  localparam int SW  = 2048;
  localparam int DIV = SW / ((1 << W) - 1);
  localparam int MAXC = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic open_sense = 1'b0;
  logic out_hiz = 1'b0;
  logic [W-1:0] tgt_pu = '0, tgt_pd = '0;
  logic [W-1:0] app_pu, app_pd;

  int vectors = 0, miscompares = 0, cycles = 0;
  int m_pu = 0, m_pd = 0, m_cnt = 0;
  bit m_hq = 1'b0;

  zq_code_seq #(.CODE_W(W), .SWEEP_CYC(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .open_sense(open_sense), .out_hiz(out_hiz),
    .tgt_pu(tgt_pu), .tgt_pd(tgt_pd), .app_pu(app_pu), .app_pd(app_pd));

  always #2.5 clk = ~clk;

  function automatic int move(input int cur, input int tgt);
    if (cur < tgt) return cur + 1;
    if (cur > tgt) return cur - 1;
    return cur;
  endfunction

  // reference model from R1, R2, R5, R6, R8, R9
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pu = 0; m_pd = 0; m_cnt = 0; m_hq = 1'b0;
    end else begin
      if (out_hiz && m_hq) begin
        if (m_cnt == DIV - 1) begin
          m_cnt = 0;
          m_pu = move(m_pu, open_sense ? MAXC : int'(tgt_pu));
          m_pd = move(m_pd, open_sense ? MAXC : int'(tgt_pd));
        end else m_cnt = m_cnt + 1;
      end
      m_hq = out_hiz;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk({req, " pu"}, int'(app_pu), m_pu);
      chk({req, " pd"}, int'(app_pd), m_pd);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R1 reset state
    rst_n = 1'b0; out_hiz = 1'b1; tgt_pu = '1; tgt_pd = '1;
    cyc(3, "R1 in reset");
    chk("R1 pu zero", int'(app_pu), 0);
    chk("R1 pd zero", int'(app_pd), 0);
    rst_n = 1'b1; tgt_pd = '0;
    // R7 full sweep with steady window, R8 pd stays on its own target
    cyc(2046, "R7 sweep");
    chk("R7 pu one short", int'(app_pu), 30);
    cyc(1, "R7 sweep end");
    chk("R7 pu at max", int'(app_pu), 31);
    chk("R8 pd independent", int'(app_pd), 0);
    // R5 open sense overrides low pin target
    open_sense = 1'b1;
    cyc(2100, "R5 open");
    chk("R5 pd forced max", int'(app_pd), 31);
    chk("R9 pu holds at target", int'(app_pu), 31);
    // R2 single-edge pulses never open a window
    open_sense = 1'b0; tgt_pu = '0; tgt_pd = '0;
    for (int i = 0; i < 300; i++) begin
      out_hiz = i[0];
      cyc(1, "R2 pulses");
    end
    out_hiz = 1'b0;
    cyc(200, "R2 driven");
    chk("R2 pu unchanged", int'(app_pu), 31);
    chk("R2 pd unchanged", int'(app_pd), 31);
    // R6 count held across gap: 39 + 27 windows = 66
    rst_n = 1'b0; cyc(2, "R1 rerst");
    rst_n = 1'b1; tgt_pu = '1; tgt_pd = '1; out_hiz = 1'b1;
    cyc(40, "R6 burst1");
    out_hiz = 1'b0; cyc(10, "R6 gap");
    out_hiz = 1'b1; cyc(27, "R6 burst2");
    chk("R6 pu before step", int'(app_pu), 0);
    cyc(1, "R6 step");
    chk("R6 pu stepped", int'(app_pu), 1);
    chk("R6 pd stepped", int'(app_pd), 1);
    // random traffic: R3, R4, R9 against model
    for (int i = 0; i < 6000; i++) begin
      out_hiz = ($urandom % 4) != 0;
      if ($urandom % 200 == 0) begin
        tgt_pu = W'($urandom);
        tgt_pd = W'($urandom);
      end
      if ($urandom % 500 == 0) open_sense = ~open_sense;
      if (i == 3000) rst_n = 1'b0;
      if (i == 3002) rst_n = 1'b1;
      cyc(1, "R4 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule